// File: doc/BRIEF.md
# Aperture Page Remapper

This block translates bus addresses that fall inside a fixed aperture window into physical addresses, one 4 KB page at a time. The window starts at a parameterised base and spans a parameterised number of pages. Each page owns a 32-bit table entry. The top bit of the entry says whether the page is mapped, and the bits from 30 down to 12 give the physical page base.

Software reaches the table through three registers on a simple 32-bit register bus. It first selects a page by writing that page's full aperture byte address into a selector register. It can then write or read the selected entry through a data register. A control register switches translation on and off. It can be read back, so software can use that read to confirm that its earlier writes have landed.

Other logic presents a bus address on a separate lookup port. One cycle later the port returns either the physical page base joined with the untranslated 12-bit page offset, or a fault flag with a zero address.

Top module: `aperture_remap`

## Requirements
- R1: After reset every table entry reads as zero, translation is off, the register read data is zero and no lookup result is presented.
- R2: A write to offset 0x24 sets the translation enable from bit 0 of the write data. A read of 0x24 returns the enable in bit 0 and zeros in bits 31:1.
- R3: A write to offset 0x28 with an address inside the aperture selects page (address − base) >> 12. A read of 0x28 returns base + page × 4096. A write with an address outside the aperture leaves the selection unchanged.
- R4: A write to offset 0x2C stores all 32 bits of the write data in the selected entry. A read of 0x2C returns the selected entry.
- R5: A lookup inside the aperture, made while translation is on and the entry's bit 31 is set, returns (entry AND 0x7FFF_F000) OR address[11:0] with the fault flag low.
- R6: A lookup whose entry has bit 31 clear returns the fault flag high and an address of zero.
- R7: A lookup below the base, or at or above base + pages × 4096, returns the fault flag high and an address of zero.
- R8: While translation is off, every lookup returns the fault flag high and an address of zero.
- R9: When a lookup and an entry write to the same page happen in the same cycle, the lookup returns the translation from the entry as it stood before the write.
- R10: The result valid output is high exactly in the cycle after each lookup request. When it is low, the result address and the fault flag are zero.
- R11: A register read returns its data in the cycle after the request. A read of any offset other than 0x24, 0x28 or 0x2C returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_off | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after a read |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Bus address to translate |
| res_valid | output | 1 | Lookup result present |
| res_addr | output | 32 | Translated physical address, or zero on a fault |
| res_fault | output | 1 | Lookup found no usable mapping |

## Verification
The assertions check several rules on every cycle. The result must follow each request by exactly one cycle and must be zero when idle. A fault must carry a zero address, and a hit must carry the request's page offset unchanged. Out-of-range and disabled lookups must fault, a control write must set the enable, and a selector write outside the window must leave the selected page unchanged. The other behaviours need values that only the bench's scenarios supply: the physical base stored in an entry, the readback of the selector and entry registers, the first and last pages of the window, and a write to a page that collides with a lookup of the same page.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int DATA_W    = 32;
  localparam int REG_OFF_W = 8;
  localparam int PG_SHIFT  = 12;
  localparam int VLD_BIT   = 31;

  localparam logic [REG_OFF_W-1:0] OFF_CTRL  = 8'h24;
  localparam logic [REG_OFF_W-1:0] OFF_PGSEL = 8'h28;
  localparam logic [REG_OFF_W-1:0] OFF_PTE   = 8'h2C;

  localparam logic [DATA_W-1:0] FRAME_MASK =
    ~((DATA_W'(1) << PG_SHIFT) - DATA_W'(1)) & ~(DATA_W'(1) << VLD_BIT);

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_CTRL,
    ACC_PGSEL,
    ACC_PTE
  } acc_e;

  typedef struct packed {
    logic              valid;
    logic              fault;
    logic [DATA_W-1:0] addr;
  } lk_res_t;
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import remap_pkg::*;
#(
  parameter logic [DATA_W-1:0] APER_BASE  = 32'h5800_0000,
  parameter int                PAGE_COUNT = 64,
  parameter int                IDX_W      = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_sel,
  input  logic                 reg_wr,
  input  logic [REG_OFF_W-1:0] reg_off,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  input  logic [DATA_W-1:0]    pte_rdata,
  output logic                 en_q,
  output logic [IDX_W-1:0]     sel_idx,
  output logic                 pte_we,
  output logic [DATA_W-1:0]    pte_wdata
);
  localparam logic [DATA_W:0] SPAN = (DATA_W+1)'(PAGE_COUNT) << PG_SHIFT;

  acc_e              acc;
  logic [DATA_W-1:0] rel;
  logic              in_ap;
  logic              en_d, en_ce;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_ce;
  logic [DATA_W-1:0] rd_q, rd_d;
  logic              rd_ce;

  // offset decode
  always_comb begin
    case (reg_off)
      OFF_CTRL:  acc = ACC_CTRL;
      OFF_PGSEL: acc = ACC_PGSEL;
      OFF_PTE:   acc = ACC_PTE;
      default:   acc = ACC_NONE;
    endcase
  end

  // aperture check on the selector write value
  always_comb begin
    rel   = reg_wdata - APER_BASE;
    in_ap = (reg_wdata >= APER_BASE) && ({1'b0, rel} < SPAN);
  end

  // next state
  always_comb begin
    en_ce  = reg_sel && reg_wr && (acc == ACC_CTRL);
    en_d   = reg_wdata[0];
    idx_ce = reg_sel && reg_wr && (acc == ACC_PGSEL) && in_ap;
    idx_d  = rel[PG_SHIFT +: IDX_W];
    rd_ce  = reg_sel && !reg_wr;
    case (acc)
      ACC_CTRL:  rd_d = {{(DATA_W-1){1'b0}}, en_q};
      ACC_PGSEL: rd_d = APER_BASE + (DATA_W'(idx_q) << PG_SHIFT);
      ACC_PTE:   rd_d = pte_rdata;
      default:   rd_d = '0;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      idx_q <= '0;
      rd_q  <= '0;
    end else begin
      if (en_ce)  en_q  <= en_d;
      if (idx_ce) idx_q <= idx_d;
      if (rd_ce)  rd_q  <= rd_d;
    end
  end

  assign sel_idx   = idx_q;
  assign reg_rdata = rd_q;
  assign pte_we    = reg_sel && reg_wr && (acc == ACC_PTE);
  assign pte_wdata = reg_wdata;
endmodule

// File: rtl/remap_table.sv
module remap_table
  import remap_pkg::*;
#(
  parameter int PAGE_COUNT = 64,
  parameter int IDX_W      = 6,
  parameter int NRD        = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  rd_idx  [NRD],
  output logic [DATA_W-1:0] rd_data [NRD]
);
  logic [DATA_W-1:0] mem [PAGE_COUNT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PAGE_COUNT; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  // independent combinational read ports: old contents until the edge
  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = mem[rd_idx[p]];
  end
endmodule

// File: rtl/remap_lookup.sv
module remap_lookup
  import remap_pkg::*;
#(
  parameter logic [DATA_W-1:0] APER_BASE  = 32'h5800_0000,
  parameter int                PAGE_COUNT = 64,
  parameter int                IDX_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              lk_valid,
  input  logic [DATA_W-1:0] lk_addr,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic [DATA_W-1:0] entry,
  output lk_res_t           res
);
  localparam logic [DATA_W:0] SPAN = (DATA_W+1)'(PAGE_COUNT) << PG_SHIFT;

  logic [DATA_W-1:0] rel;
  logic              in_ap;
  logic              hit;
  lk_res_t           res_d, res_q;
  logic              res_ce;

  always_comb begin
    rel    = lk_addr - APER_BASE;
    in_ap  = (lk_addr >= APER_BASE) && ({1'b0, rel} < SPAN);
    lk_idx = rel[PG_SHIFT +: IDX_W];
    hit    = en && in_ap && entry[VLD_BIT];
    res_d.valid = lk_valid;
    res_d.fault = lk_valid && !hit;
    res_d.addr  = (lk_valid && hit) ?
                  ((entry & FRAME_MASK) |
                   {{(DATA_W-PG_SHIFT){1'b0}}, lk_addr[PG_SHIFT-1:0]}) : '0;
    res_ce = lk_valid || res_q.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (res_ce) begin
      res_q <= res_d;
    end
  end

  assign res = res_q;
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic [7:0]  reg_off,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_addr,
  output logic        res_valid,
  output logic [31:0] res_addr,
  output logic        res_fault
);
  localparam int IDX_W = (PAGE_COUNT > 1) ? $clog2(PAGE_COUNT) : 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              en_q;
  logic [IDX_W-1:0]  sel_idx;
  logic              pte_we;
  logic [DATA_W-1:0] pte_wdata;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  rd_idx  [2];
  logic [DATA_W-1:0] rd_data [2];
  lk_res_t           res;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  remap_regs #(
    .APER_BASE (APER_BASE),
    .PAGE_COUNT(PAGE_COUNT),
    .IDX_W     (IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .reg_sel  (reg_sel),
    .reg_wr   (reg_wr),
    .reg_off  (reg_off),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .pte_rdata(rd_data[0]),
    .en_q     (en_q),
    .sel_idx  (sel_idx),
    .pte_we   (pte_we),
    .pte_wdata(pte_wdata)
  );

  assign rd_idx[0] = sel_idx;
  assign rd_idx[1] = lk_idx;

  remap_table #(
    .PAGE_COUNT(PAGE_COUNT),
    .IDX_W     (IDX_W),
    .NRD       (2)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (pte_we),
    .widx   (sel_idx),
    .wdata  (pte_wdata),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  remap_lookup #(
    .APER_BASE (APER_BASE),
    .PAGE_COUNT(PAGE_COUNT),
    .IDX_W     (IDX_W)
  ) u_lookup (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (en_q),
    .lk_valid(lk_valid),
    .lk_addr (lk_addr),
    .lk_idx  (lk_idx),
    .entry   (rd_data[1]),
    .res     (res)
  );

  assign res_valid = res.valid;
  assign res_fault = res.fault;
  assign res_addr  = res.addr;
endmodule

// File: rtl/remap_chk.sv
module remap_chk
  import remap_pkg::*;
#(
  parameter logic [31:0] APER_BASE  = 32'h5800_0000,
  parameter int          PAGE_COUNT = 64,
  parameter int          IDX_W      = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_wr,
  input logic [7:0]       reg_off,
  input logic [31:0]      reg_wdata,
  input logic             lk_valid,
  input logic [31:0]      lk_addr,
  input logic             res_valid,
  input logic [31:0]      res_addr,
  input logic             res_fault,
  input logic             en,
  input logic [IDX_W-1:0] idx
);
  localparam logic [32:0] APER_END = {1'b0, APER_BASE} + (33'(PAGE_COUNT) << PG_SHIFT);

  logic lk_out, wr_out;
  assign lk_out = (lk_addr < APER_BASE) || ({1'b0, lk_addr} >= APER_END);
  assign wr_out = (reg_wdata < APER_BASE) || ({1'b0, reg_wdata} >= APER_END);

  // R10
  resv_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> res_valid);
  // R10
  resv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !res_valid);
  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!res_fault && res_addr == 32'd0));
  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_fault) |-> res_addr == 32'd0);
  // R5
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid ##1 (res_valid && !res_fault) |-> res_addr[11:0] == $past(lk_addr[11:0]));
  // R7
  oor_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_out) |=> res_fault);
  // R8
  off_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !en) |=> res_fault);
  // R2
  ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_off == OFF_CTRL) |=> en == $past(reg_wdata[0]));
  // R3
  sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel && reg_wr && reg_off == OFF_PGSEL && wr_out) |=> $stable(idx));
endmodule

bind aperture_remap remap_chk #(
  .APER_BASE (APER_BASE),
  .PAGE_COUNT(PAGE_COUNT),
  .IDX_W     (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .reg_sel  (reg_sel),
  .reg_wr   (reg_wr),
  .reg_off  (reg_off),
  .reg_wdata(reg_wdata),
  .lk_valid (lk_valid),
  .lk_addr  (lk_addr),
  .res_valid(res_valid),
  .res_addr (res_addr),
  .res_fault(res_fault),
  .en       (en_q),
  .idx      (sel_idx)
);

// File: tb/test_aperture_remap.sv
`timescale 1ns/1ps
module test_aperture_remap;
  localparam logic [31:0] BASE = 32'h5800_0000;
  localparam int          NPG  = 64;
  localparam longint      SPAN = longint'(NPG) * 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_off = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_addr = 32'h0;
  logic [31:0] reg_rdata, res_addr;
  logic        res_valid, res_fault;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  aperture_remap #(.APER_BASE(BASE), .PAGE_COUNT(NPG)) i_aperture_remap (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_addr(res_addr), .res_fault(res_fault));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_tbl [NPG];
  bit          m_en = 0;
  int          m_pg = 0;
  logic [31:0] e_rdata = 0, e_addr = 0;
  bit          e_valid = 0, e_fault = 0;
  string       e_rtag = "R1", e_ltag = "R1";

  initial for (int i = 0; i < NPG; i++) m_tbl[i] = 32'h0;

  always @(posedge clk) begin
    longint rel;
    int     pg;
    logic [31:0] ent;
    if (!rst_n) begin
      for (int i = 0; i < NPG; i++) m_tbl[i] <= 32'h0;
      m_en <= 0; m_pg <= 0; e_rdata <= 0; e_valid <= 0; e_fault <= 0; e_addr <= 0;
    end else begin
      e_valid <= lk_valid;
      if (lk_valid) begin
        rel = longint'(lk_addr) - longint'(BASE);
        if (rel < 0 || rel >= SPAN) begin
          e_fault <= 1; e_addr <= 0; e_ltag <= "R7";
        end else if (!m_en) begin
          e_fault <= 1; e_addr <= 0; e_ltag <= "R8";
        end else begin
          pg  = int'(rel / 4096);
          ent = m_tbl[pg];
          if (ent[31]) begin
            e_fault <= 0; e_addr <= {1'b0, ent[30:12], lk_addr[11:0]}; e_ltag <= "R5";
          end else begin
            e_fault <= 1; e_addr <= 0; e_ltag <= "R6";
          end
          if (reg_sel && reg_wr && reg_off == 8'h2C && pg == m_pg) e_ltag <= "R9";
        end
      end else begin
        e_fault <= 0; e_addr <= 0; e_ltag <= "R10";
      end
      if (reg_sel && reg_wr) begin
        if (reg_off == 8'h24) m_en <= reg_wdata[0];
        else if (reg_off == 8'h28) begin
          rel = longint'(reg_wdata) - longint'(BASE);
          if (rel >= 0 && rel < SPAN) m_pg <= int'(rel / 4096);
        end else if (reg_off == 8'h2C) m_tbl[m_pg] <= reg_wdata;
      end else if (reg_sel) begin
        case (reg_off)
          8'h24: begin e_rdata <= {31'b0, m_en}; e_rtag <= "R2"; end
          8'h28: begin e_rdata <= BASE + 32'(m_pg) * 4096; e_rtag <= "R3"; end
          8'h2C: begin e_rdata <= m_tbl[m_pg]; e_rtag <= "R4"; end
          default: begin e_rdata <= 0; e_rtag <= "R11"; end
        endcase
      end
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    chk("R10", {31'b0, res_valid}, {31'b0, e_valid});
    chk(e_ltag, {31'b0, res_fault}, {31'b0, e_fault});
    chk(e_ltag, res_addr, e_addr);
    chk(e_rtag, reg_rdata, e_rdata);
  end

  task automatic wr(logic [7:0] off, logic [31:0] d);
    reg_sel = 1; reg_wr = 1; reg_off = off; reg_wdata = d;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] off, logic [31:0] exp, string tag);
    reg_sel = 1; reg_wr = 0; reg_off = off;
    @(negedge clk);
    reg_sel = 0;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic lk(logic [31:0] a, logic [31:0] exp_a, bit exp_f, string tag);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    chk(tag, {31'b0, res_fault}, {31'b0, exp_f});
    chk(tag, res_addr, exp_a);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog act=%0d exp<%0d", cyc, 20000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", {31'b0, res_valid}, 32'd0);
    rd(8'h24, 32'h0, "R1");
    rd(8'h2C, 32'h0, "R1");
    // R8 translation off, even with a mapped page
    wr(8'h28, BASE + 32'h3000);
    wr(8'h2C, 32'h8000_9000);
    lk(BASE + 32'h3010, 32'h0, 1, "R8");
    // R2 enable and readback
    wr(8'h24, 32'h0000_0001);
    rd(8'h24, 32'h1, "R2");
    lk(BASE + 32'h3010, 32'h0000_9010, 0, "R5");
    // R3 unaligned selector write reads back page aligned
    wr(8'h28, BASE + 32'h5123);
    rd(8'h28, BASE + 32'h5000, "R3");
    // R4 full entry stored
    wr(8'h2C, 32'h8001_2ABC);
    rd(8'h2C, 32'h8001_2ABC, "R4");
    lk(BASE + 32'h5345, 32'h0001_2345, 0, "R5");
    // R3 out-of-aperture selector writes ignored
    wr(8'h28, 32'h1000_0000);
    rd(8'h28, BASE + 32'h5000, "R3");
    wr(8'h28, BASE + 32'h0004_0000);
    rd(8'h28, BASE + 32'h5000, "R3");
    wr(8'h28, BASE - 32'h1);
    rd(8'h2C, 32'h8001_2ABC, "R3");
    // R6 invalid entry
    wr(8'h28, BASE + 32'h7000);
    wr(8'h2C, 32'h0003_4000);
    lk(BASE + 32'h7004, 32'h0, 1, "R6");
    lk(BASE + 32'h9000, 32'h0, 1, "R6");
    // R7 edges of the window
    lk(BASE - 32'h1, 32'h0, 1, "R7");
    lk(BASE + 32'h0004_0000, 32'h0, 1, "R7");
    wr(8'h28, BASE + 32'h0003_F000);
    wr(8'h2C, 32'h8777_7000);
    lk(BASE + 32'h0003_FFFF, 32'h0777_7FFF, 0, "R5");
    wr(8'h28, BASE);
    wr(8'h2C, 32'hFFFF_FFFF);
    lk(BASE, 32'h7FFF_F000, 0, "R5");
    // R9 same-cycle write and lookup of one page
    wr(8'h28, BASE + 32'h5000);
    reg_sel = 1; reg_wr = 1; reg_off = 8'h2C; reg_wdata = 32'h8055_5000;
    lk_valid = 1; lk_addr = BASE + 32'h5001;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; lk_valid = 0;
    chk("R9", res_addr, 32'h0001_2001);
    lk(BASE + 32'h5001, 32'h0055_5001, 0, "R9");
    // R11 unused offsets
    rd(8'h00, 32'h0, "R11");
    rd(8'h30, 32'h0, "R11");
    rd(8'h26, 32'h0, "R11");
    // R10 back-to-back lookups
    lk_valid = 1; lk_addr = BASE + 32'h5002;
    @(negedge clk);
    chk("R10", {31'b0, res_valid}, 32'd1);
    lk_addr = BASE + 32'h3003;
    @(negedge clk);
    lk_valid = 0;
    chk("R10", res_addr, 32'h0000_9003);
    @(negedge clk);
    chk("R10", {31'b0, res_valid}, 32'd0);
    // whole-table pattern
    for (int i = 0; i < NPG; i++) begin
      wr(8'h28, BASE + 32'(i) * 4096);
      wr(8'h2C, ((i % 3) == 0) ? (32'(i) << 12) : (32'h8000_0000 | (32'(i + 256) << 12)));
    end
    for (int i = 0; i < NPG; i++) begin
      logic [31:0] off = 32'((i * 37) & 12'hFFF);
      if ((i % 3) == 0) lk(BASE + 32'(i) * 4096 + off, 32'h0, 1, "R6");
      else lk(BASE + 32'(i) * 4096 + off, (32'(i + 256) << 12) | off, 0, "R5");
    end
    // R8 disable again
    wr(8'h24, 32'h0);
    rd(8'h24, 32'h0, "R2");
    lk(BASE + 32'h1000, 32'h0, 1, "R8");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule